// File: doc/BRIEF.md
# Linear Congruential Random Number Generator

This block steps a 32-bit pseudorandom state through the affine recurrence X ← A·X + C. Only the low 32 bits of the result are kept, so the modulus 2^32 comes for free. Each accepted request advances the state by one step. The block then presents the new state together with a range-reduced copy in 0..N-1. That copy is the upper half of the 64-bit product of the state and N, which draws on the high-order state bits.

Software-independent control is minimal. A load strobe installs a seed, selects one of four multiplier presets and sets the increment, forcing the increment odd. A next strobe requests one step. A one-cycle valid pulse marks the cycle when a fresh value and its scaled form appear.

The controller has three states. S_IDLE waits and accepts a next strobe (transition T_ACCEPT to S_STEP). S_STEP commits the new state (transition T_COMMIT to S_SCALE). S_SCALE registers the outputs and raises valid (transition T_EMIT back to S_IDLE). A load in any state takes transition T_ABORT to S_IDLE.

Top module: `lcg_rng`

## Requirements
- R1: After reset the state is 0, A = 69069, C = 69069, value_o and scaled_o are 0 and valid_o is low.
- R2: Each step sets the state to the low 32 bits of A·X + C, and value_o shows that new state when valid_o rises.
- R3: A next strobe sampled in S_IDLE makes valid_o high for exactly one cycle, on the third rising edge counting the sampling edge as the first. A next strobe sampled in S_STEP or S_SCALE is ignored.
- R4: A load installs seed_i as the state and inc_i with bit 0 forced to 1 as C, so an even increment becomes odd.
- R5: A load sampled together with a next strobe wins, and no step is taken for that strobe. A load sampled in S_STEP or S_SCALE cancels the pending step, so no valid pulse follows. The next step starts from the loaded seed.
- R6: When valid_o rises, scaled_o equals bits 63:32 of the 64-bit product of the new state and range_i, with range_i sampled on that same edge.
- R7: When range_i is 0, scaled_o is 0.
- R8: A load latches the multiplier from mul_sel_i: 00 gives 1812433253, 01 gives 1566083941, 10 gives 69069 and 11 gives 1664525.
- R9: value_o and scaled_o hold their values between valid pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Install seed, multiplier preset and increment |
| seed_i | input | 32 | Seed value for a load |
| mul_sel_i | input | 2 | Multiplier preset index for a load |
| inc_i | input | 32 | Increment for a load, bit 0 forced high |
| next_i | input | 1 | Request one step |
| range_i | input | 32 | Range N for the scaled output |
| value_o | output | 32 | Latest state |
| scaled_o | output | 32 | Latest state scaled into 0..N-1 |
| valid_o | output | 1 | One-cycle pulse marking new outputs |

## Verification
The bench runs more than a thousand steps under all four multiplier presets. It covers range values of 0, 1, 2^32-1 and mixed widths, and compares each step with 64-bit arithmetic. A design that kept the low product half, or took a modulo, would miss the scaled value almost every time. A design that carried bits past 32 would diverge after the first wrap. Two further cases are a next strobe held for two cycles and a load during a pending step: a controller that re-accepted the strobe would step twice, and one that let the load lose would emit a pulse from the stale state. An even increment is loaded to catch a missing force-odd, and a zero range is checked against a scaler that is not masked.

// File: rtl/lcg_pkg.sv
package lcg_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_STEP  = 2'd1,
        S_SCALE = 2'd2
    } lcg_state_e;

    // Multiplier preset table indexed by the load-time select
    function automatic logic [31:0] mult_preset(input logic [1:0] sel);
        logic [31:0] m;
        unique case (sel)
            2'd0: m = 32'd1812433253;
            2'd1: m = 32'd1566083941;
            2'd2: m = 32'd69069;
            default: m = 32'd1664525;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/lcg_step.sv
module lcg_step #(
    parameter int W = 32
) (
    input  logic [W-1:0] cur_i,
    input  logic [W-1:0] mul_i,
    input  logic [W-1:0] add_i,
    output logic [W-1:0] nxt_o
);
    // W-bit context keeps only the low half: modulo 2^W for free
    assign nxt_o = cur_i * mul_i + add_i;
endmodule

// File: rtl/lcg_scale.sv
module lcg_scale #(
    parameter int W = 32
) (
    input  logic [W-1:0] state_i,
    input  logic [W-1:0] range_i,
    output logic [W-1:0] hi_o
);
    localparam int PW = 2 * W;

    logic [PW-1:0] prod;
    logic [W-1:0]  hi_raw;

    assign prod   = {{W{1'b0}}, state_i} * {{W{1'b0}}, range_i};
    assign hi_raw = W'(prod >> W);
    assign hi_o   = (range_i == '0) ? '0 : hi_raw;
endmodule

// File: rtl/lcg_rng.sv
module lcg_rng
    import lcg_pkg::*;
#(
    parameter int          W       = 32,
    parameter logic [31:0] RESET_A = 32'd69069,
    parameter logic [31:0] RESET_C = 32'd69069
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] seed_i,
    input  logic [1:0]   mul_sel_i,
    input  logic [W-1:0] inc_i,
    input  logic         next_i,
    input  logic [W-1:0] range_i,
    output logic [W-1:0] value_o,
    output logic [W-1:0] scaled_o,
    output logic         valid_o
);

    lcg_state_e  st_q, st_d;
    logic [W-1:0] x_q, a_q, c_q;
    logic [W-1:0] x_nxt, scaled_nxt;

    lcg_step #(.W(W)) u_step (
        .cur_i (x_q),
        .mul_i (a_q),
        .add_i (c_q),
        .nxt_o (x_nxt)
    );

    lcg_scale #(.W(W)) u_scale (
        .state_i (x_q),
        .range_i (range_i),
        .hi_o    (scaled_nxt)
    );

    // Next-state logic: load aborts from any state
    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d = S_IDLE;
        end else begin
            unique case (st_q)
                S_IDLE:  if (next_i) st_d = S_STEP;
                S_STEP:  st_d = S_SCALE;
                S_SCALE: st_d = S_IDLE;
                default: st_d = S_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_q      <= '0;
            a_q      <= W'(RESET_A);
            c_q      <= W'(RESET_C) | W'(1);
            value_o  <= '0;
            scaled_o <= '0;
            valid_o  <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (load_i) begin
                x_q <= seed_i;
                a_q <= W'(mult_preset(mul_sel_i));
                c_q <= inc_i | W'(1);
            end else begin
                unique case (st_q)
                    S_STEP:  x_q <= x_nxt;
                    S_SCALE: begin
                        value_o  <= x_q;
                        scaled_o <= scaled_nxt;
                        valid_o  <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R3: valid is a single-cycle pulse
    p_valid_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R3: a pending scale without load yields a pulse
    p_scale_emits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_SCALE && !load_i) |=> valid_o);

    // R5: a load overrides everything and installs the seed
    p_load_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (x_q == $past(seed_i) && !valid_o));

    // R6: scaled value stays below a nonzero range
    p_scale_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(range_i) != '0) |-> (scaled_o < $past(range_i)));

    // R7: zero range gives zero
    p_zero_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(range_i) == '0) |-> (scaled_o == '0));

    // R9: outputs hold when no pulse
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != S_SCALE) |=> ($stable(value_o) && $stable(scaled_o)));

endmodule

// File: tb/tb_lcg_rng.sv
module tb_lcg_rng;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_i = 1'b0;
    logic [31:0] seed_i = '0;
    logic [1:0]  mul_sel_i = '0;
    logic [31:0] inc_i = '0;
    logic        next_i = 1'b0;
    logic [31:0] range_i = '0;
    logic [31:0] value_o, scaled_o;
    logic        valid_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [31:0] rx, ra, rc;

    always #5 clk = ~clk;

    lcg_rng dut (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .seed_i(seed_i),
        .mul_sel_i(mul_sel_i), .inc_i(inc_i), .next_i(next_i),
        .range_i(range_i), .value_o(value_o), .scaled_o(scaled_o),
        .valid_o(valid_o)
    );

    function automatic logic [31:0] ref_mult(input logic [1:0] s);
        logic [31:0] t [4] = '{32'd1812433253, 32'd1566083941, 32'd69069, 32'd1664525};
        return t[s];
    endfunction

    function automatic logic [31:0] ref_scale(input logic [31:0] x, input logic [31:0] n);
        logic [63:0] p;
        p = {32'd0, x} * {32'd0, n};
        return p[63:32];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_load(input logic [31:0] s, input logic [1:0] sel, input logic [31:0] c);
        @(negedge clk);
        load_i = 1'b1; seed_i = s; mul_sel_i = sel; inc_i = c;
        @(negedge clk);
        load_i = 1'b0;
        rx = s; ra = ref_mult(sel); rc = c | 32'd1;
    endtask

    task automatic do_step(input logic [31:0] n, input int hold);
        logic [63:0] full;
        logic [31:0] v_prev, s_prev;
        range_i = n;
        @(negedge clk);
        next_i = 1'b1;
        if (hold > 1) @(negedge clk);
        @(negedge clk);
        next_i = 1'b0;
        if (hold == 1) begin
            @(negedge clk);
        end
        chk("R3 no early valid", {31'd0, valid_o}, 32'd0);
        @(negedge clk);
        full = {32'd0, ra} * {32'd0, rx} + {32'd0, rc};
        rx = full[31:0];
        chk("R3 valid pulse", {31'd0, valid_o}, 32'd1);
        chk("R2 value", value_o, rx);
        chk(n == 0 ? "R7 zero range" : "R6 scaled", scaled_o, ref_scale(rx, n));
        v_prev = value_o; s_prev = scaled_o;
        @(negedge clk);
        chk("R3 pulse ends", {31'd0, valid_o}, 32'd0);
        chk("R9 value held", value_o, v_prev);
        chk("R9 scaled held", scaled_o, s_prev);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] rng_n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 value", value_o, 32'd0);
        chk("R1 scaled", scaled_o, 32'd0);
        chk("R1 valid", {31'd0, valid_o}, 32'd0);
        rx = 32'd0; ra = 32'd69069; rc = 32'd69069;
        do_step(32'hFFFF_FFFF, 1);
        chk("R1 first step", value_o, 32'd69069);

        // R8 and R2: every preset, many ranges
        for (int sel = 0; sel < 4; sel++) begin
            do_load(32'h1234_5678 + 32'(sel) * 32'h0101_0101, 2'(sel), 32'd12345 + 32'(sel) * 2);
            for (int k = 0; k < 300; k++) begin
                case (k % 5)
                    0: rng_n = 32'd0;
                    1: rng_n = 32'd1;
                    2: rng_n = 32'hFFFF_FFFF;
                    3: rng_n = 32'd6;
                    default: rng_n = 32'(k) * 32'd7919 + 32'd3;
                endcase
                do_step(rng_n, 1);
            end
        end

        // R4: even increment forced odd
        do_load(32'd1000, 2'd2, 32'd2);
        do_step(32'd100, 1);
        chk("R4 forced odd", value_o, 32'd69069 * 32'd1000 + 32'd3);

        // R3: strobe held over a busy cycle steps once
        do_step(32'd50, 2);

        // R5: load and next together
        @(negedge clk);
        load_i = 1'b1; next_i = 1'b1; seed_i = 32'hDEAD_BEEF; mul_sel_i = 2'd3; inc_i = 32'd7;
        @(negedge clk);
        load_i = 1'b0; next_i = 1'b0;
        rx = 32'hDEAD_BEEF; ra = 32'd1664525; rc = 32'd7;
        for (int i = 0; i < 4; i++) chk("R5 no step on load", {31'd0, valid_o}, 32'd0);
        repeat (4) @(negedge clk);
        do_step(32'd1000, 1);

        // R5: load during pending step aborts it
        @(negedge clk);
        next_i = 1'b1;
        @(negedge clk);
        next_i = 1'b0; load_i = 1'b1; seed_i = 32'd42; mul_sel_i = 2'd0; inc_i = 32'd11;
        @(negedge clk);
        load_i = 1'b0;
        rx = 32'd42; ra = 32'd1812433253; rc = 32'd11;
        for (int i = 0; i < 4; i++) begin
            chk("R5 abort no pulse", {31'd0, valid_o}, 32'd0);
            @(negedge clk);
        end
        do_step(32'd77, 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule